// File: doc/BRIEF.md
# DDR3 Reset and Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface and walks the attached device through its power-up or warm-reset bring-up. It drives the memory reset pin low and keeps clock-enable low. It then releases reset and waits for the device to stabilise before raising clock-enable. After the exit-reset interval it writes the four mode registers and starts a long ZQ calibration. It raises a ready flag once the calibration and DLL lock intervals have run out. Until then it drives NOP on the command bus in every cycle of every wait.

All intervals are counted in controller clock cycles. The delay inputs are expected to stay static while a sequence runs. Three of the waits have a floor that is derived at elaboration time from the clock period parameter `CLK_PS`. The reset-low interval is never shorter than 100 ns. The exit-reset and mode-load intervals are never shorter than the larger of 10 ns and 5 cycles. When a configured value is below its floor, the counter loads the floor instead. A one-cycle `start_i` pulse, or the asynchronous reset, restarts the sequence from the reset-assert step. The mode register contents come in through the code inputs and are forwarded without change.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after `start_i` is sampled high, the outputs are `mem_rst_n_o`=0, `cke_o`=0, `ready_o`=0 and `cmd_o`=NOP. The sequence then restarts from its first step.
- R2: `mem_rst_n_o` stays low for max(`t_rst_i`, ceil(100000/CLK_PS)) cycles, counted from the restart.
- R3: After `mem_rst_n_o` rises, `cke_o` stays low for max(`t_stab_i`,1) cycles and then goes high.
- R4: After `cke_o` rises, NOP is driven for max(`t_xpr_i`, F) cycles, then the first mode-register write goes out. Here F = max(ceil(10000/CLK_PS), 5).
- R5: A mode-register write is `cmd_o`=4'b0000 (bit order {cs_n,ras_n,cas_n,we_n}). The four writes use `ba_o` = 3'b010, 3'b011, 3'b001, 3'b000 in that order. Each one carries `mr2_code_i`, `mr3_code_i`, `mr1_code_i` and `mr0_code_i` respectively on `addr_o`.
- R6: The first three mode-register writes are spaced max(`t_mrd_i`,1) cycles apart, measured command to command.
- R7: A long ZQ calibration (`cmd_o`=4'b0110, `addr_o` bit 10 set and all other bits zero, `ba_o`=0) goes out max(`t_mod_i`, F) cycles after the last mode-register write.
- R8: `ready_o` rises max(`t_zq_i`, `t_dllk_i`, 1) cycles after the ZQ calibration command and stays high until the next restart.
- R9: In every cycle without a command, `cmd_o` is NOP (4'b0111) with `addr_o` and `ba_o` zero. This includes the cycles after `ready_o` is high.
- R10: `odt_o` is held low at all times.
- R11: `cke_o` is never high while `mem_rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous restart request |
| t_rst_i | input | CNT_W | Reset-low interval, cycles |
| t_stab_i | input | CNT_W | Reset-release to CKE-high interval, cycles |
| t_xpr_i | input | CNT_W | CKE-high to first mode write, cycles |
| t_mrd_i | input | CNT_W | Mode-write to mode-write spacing, cycles |
| t_mod_i | input | CNT_W | Last mode write to ZQ command, cycles |
| t_zq_i | input | CNT_W | ZQ calibration interval, cycles |
| t_dllk_i | input | CNT_W | DLL lock interval, cycles |
| mr0_code_i | input | ADDR_W | Address word for mode register 0 |
| mr1_code_i | input | ADDR_W | Address word for mode register 1 |
| mr2_code_i | input | ADDR_W | Address word for mode register 2 |
| mr3_code_i | input | ADDR_W | Address word for mode register 3 |
| mem_rst_n_o | output | 1 | Active-low memory reset |
| cke_o | output | 1 | Clock enable |
| odt_o | output | 1 | On-die termination control |
| cmd_o | output | 4 | {cs_n,ras_n,cas_n,we_n} |
| ba_o | output | 3 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| ready_o | output | 1 | Initialization complete |

## Verification
The sequencer is a single chain of counted phases, so a wrong phase or a miscounted wait moves every later edge of the outputs. It shows up at the ports within one cycle of the expected event. It appears as a reset edge or CKE edge that is early or late, a missing mode write, a misplaced mode write, or a write with the wrong bank or code. The bench compares every output on every cycle against a schedule worked out from the delay inputs and the floors. A fault is therefore seen in the first cycle where it changes an output, and no end-of-sequence check is needed. Restarts in the middle of the mode-write phase confirm that no stale phase or register index survives a restart.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  typedef enum logic [2:0] {
    ST_RST, ST_STAB, ST_XPR, ST_MRS, ST_ZQ, ST_RDY
  } state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_ZQCL = 4'b0110;
endpackage

// File: rtl/dinit_timer.sv
module dinit_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == lim_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || last_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dinit_limits.sv
module dinit_limits
  import dinit_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned CLK_PS = 1250
) (
  input  state_e           state_i,
  input  logic [1:0]       idx_i,
  input  logic [CNT_W-1:0] t_rst_i,
  input  logic [CNT_W-1:0] t_stab_i,
  input  logic [CNT_W-1:0] t_xpr_i,
  input  logic [CNT_W-1:0] t_mrd_i,
  input  logic [CNT_W-1:0] t_mod_i,
  input  logic [CNT_W-1:0] t_zq_i,
  input  logic [CNT_W-1:0] t_dllk_i,
  output logic [CNT_W-1:0] lim_o
);
  localparam int unsigned RST_CYC  = (100000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned NS10_CYC = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned SHORT_CYC = (NS10_CYC > 5) ? NS10_CYC : 5;
  localparam logic [CNT_W-1:0] RST_FLOOR   = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] SHORT_FLOOR = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

  function automatic logic [CNT_W-1:0] at_least(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] f);
    return (v < f) ? f : v;
  endfunction

  logic [CNT_W-1:0] zq_max;
  assign zq_max = (t_zq_i > t_dllk_i) ? t_zq_i : t_dllk_i;

  always_comb begin
    unique case (state_i)
      ST_RST:  lim_o = at_least(t_rst_i, RST_FLOOR);
      ST_STAB: lim_o = at_least(t_stab_i, ONE);
      ST_XPR:  lim_o = at_least(t_xpr_i, SHORT_FLOOR);
      ST_MRS:  lim_o = (idx_i == 2'd3) ? at_least(t_mod_i, SHORT_FLOOR)
                                       : at_least(t_mrd_i, ONE);
      ST_ZQ:   lim_o = at_least(zq_max, ONE);
      default: lim_o = ONE;
    endcase
  end
endmodule

// File: rtl/dinit_cmd.sv
module dinit_cmd
  import dinit_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  state_e            state_i,
  input  logic [1:0]        idx_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] mr0_code_i,
  input  logic [ADDR_W-1:0] mr1_code_i,
  input  logic [ADDR_W-1:0] mr2_code_i,
  input  logic [ADDR_W-1:0] mr3_code_i,
  output logic [3:0]        cmd_o,
  output logic [2:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned ZQ_BIT = 10;

  logic [ADDR_W-1:0] code_tab [4];
  assign code_tab[0] = mr2_code_i;
  assign code_tab[1] = mr3_code_i;
  assign code_tab[2] = mr1_code_i;
  assign code_tab[3] = mr0_code_i;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (first_i && state_i == ST_MRS) begin
      cmd_o  = CMD_MRS;
      // write order 2,3,1,0
      ba_o   = {1'b0, ~idx_i[1], idx_i[1] ^ idx_i[0]};
      addr_o = code_tab[idx_i];
    end else if (first_i && state_i == ST_ZQ) begin
      cmd_o          = CMD_ZQCL;
      addr_o[ZQ_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import dinit_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned CLK_PS = 1250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  t_rst_i,
  input  logic [CNT_W-1:0]  t_stab_i,
  input  logic [CNT_W-1:0]  t_xpr_i,
  input  logic [CNT_W-1:0]  t_mrd_i,
  input  logic [CNT_W-1:0]  t_mod_i,
  input  logic [CNT_W-1:0]  t_zq_i,
  input  logic [CNT_W-1:0]  t_dllk_i,
  input  logic [ADDR_W-1:0] mr0_code_i,
  input  logic [ADDR_W-1:0] mr1_code_i,
  input  logic [ADDR_W-1:0] mr2_code_i,
  input  logic [ADDR_W-1:0] mr3_code_i,
  output logic              mem_rst_n_o,
  output logic              cke_o,
  output logic              odt_o,
  output logic [3:0]        cmd_o,
  output logic [2:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);
  state_e           state_q;
  logic [1:0]       idx_q;
  logic [CNT_W-1:0] lim;
  logic             first, last;

  dinit_limits #(.CNT_W(CNT_W), .CLK_PS(CLK_PS)) i_limits (
    .state_i (state_q), .idx_i (idx_q),
    .t_rst_i (t_rst_i), .t_stab_i (t_stab_i), .t_xpr_i (t_xpr_i),
    .t_mrd_i (t_mrd_i), .t_mod_i (t_mod_i), .t_zq_i (t_zq_i),
    .t_dllk_i(t_dllk_i), .lim_o (lim)
  );

  dinit_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .restart_i (start_i),
    .lim_i (lim), .first_o (first), .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RST;
      idx_q   <= '0;
    end else if (last) begin
      unique case (state_q)
        ST_RST:  state_q <= ST_STAB;
        ST_STAB: state_q <= ST_XPR;
        ST_XPR:  state_q <= ST_MRS;
        ST_MRS: begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) state_q <= ST_ZQ;
        end
        ST_ZQ:   state_q <= ST_RDY;
        default: state_q <= ST_RDY;
      endcase
    end
  end

  dinit_cmd #(.ADDR_W(ADDR_W)) i_cmd (
    .state_i (state_q), .idx_i (idx_q), .first_i (first),
    .mr0_code_i (mr0_code_i), .mr1_code_i (mr1_code_i),
    .mr2_code_i (mr2_code_i), .mr3_code_i (mr3_code_i),
    .cmd_o (cmd_o), .ba_o (ba_o), .addr_o (addr_o)
  );

  assign mem_rst_n_o = (state_q != ST_RST);
  assign cke_o       = !(state_q inside {ST_RST, ST_STAB});
  assign ready_o     = (state_q == ST_RDY);
  assign odt_o       = 1'b0;
endmodule

// File: rtl/dinit_sva.sv
module dinit_sva
  import dinit_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       mem_rst_n_o,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic       ready_o
);
  a_r11_cke_low_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rst_n_o |-> !cke_o);

  a_r1_restart_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!mem_rst_n_o && !cke_o && !ready_o && cmd_o == CMD_NOP));

  a_r8_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);

  a_r9_nop_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cmd_o == CMD_NOP);

  a_r5_mrs_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (cke_o && mem_rst_n_o && !ready_o));

  a_r7_single_zq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ZQCL) |=> (cmd_o != CMD_ZQCL));
endmodule

bind ddr3_init_seq dinit_sva i_dinit_sva (
  .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
  .mem_rst_n_o (mem_rst_n_o), .cke_o (cke_o), .cmd_o (cmd_o),
  .ready_o (ready_o)
);

// File: tb/test_ddr3_init_seq.sv
module test_ddr3_init_seq;
  localparam int CNT_W = 20;
  localparam int AW    = 14;
  localparam int CLK_PS = 8000;
  localparam int RST_FL = (100000 + CLK_PS - 1) / CLK_PS;
  localparam int SH_FL  = ((10000 + CLK_PS - 1) / CLK_PS > 5) ? (10000 + CLK_PS - 1) / CLK_PS : 5;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [CNT_W-1:0] t_rst, t_stab, t_xpr, t_mrd, t_mod, t_zq, t_dllk;
  logic [AW-1:0] mr0, mr1, mr2, mr3;
  logic mem_rst_n, cke, odt, ready;
  logic [3:0] cmd;
  logic [2:0] ba;
  logic [AW-1:0] addr;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int sa, sb, sc, sm, sd, se;

  always #4 clk_i = ~clk_i;

  ddr3_init_seq #(.CNT_W(CNT_W), .ADDR_W(AW), .CLK_PS(CLK_PS)) i_ddr3_init_seq (
    .clk_i, .rst_ni, .start_i,
    .t_rst_i(t_rst), .t_stab_i(t_stab), .t_xpr_i(t_xpr), .t_mrd_i(t_mrd),
    .t_mod_i(t_mod), .t_zq_i(t_zq), .t_dllk_i(t_dllk),
    .mr0_code_i(mr0), .mr1_code_i(mr1), .mr2_code_i(mr2), .mr3_code_i(mr3),
    .mem_rst_n_o(mem_rst_n), .cke_o(cke), .odt_o(odt), .cmd_o(cmd),
    .ba_o(ba), .addr_o(addr), .ready_o(ready)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // vector: {rst_n, cke, odt, ready, cmd[3:0], ba[2:0], addr}
  function automatic logic [24:0] pack(input logic r, c, o, rd, input logic [3:0] cm,
                                       input logic [2:0] b, input logic [AW-1:0] a);
    return {r, c, o, rd, cm, b, a};
  endfunction

  task automatic set_sched();
    sa = imax(int'(t_rst), RST_FL);
    sb = sa + imax(int'(t_stab), 1);
    sc = sb + imax(int'(t_xpr), SH_FL);
    sm = imax(int'(t_mrd), 1);
    sd = sc + 3 * sm + imax(int'(t_mod), SH_FL);
    se = sd + imax(imax(int'(t_zq), int'(t_dllk)), 1);
  endtask

  function automatic logic [24:0] exp_vec(input int k);
    logic [3:0] cm = 4'b0111;
    logic [2:0] b = 3'b000;
    logic [AW-1:0] a = '0;
    if (k == sc)               begin cm = 4'b0000; b = 3'b010; a = mr2; end
    else if (k == sc + sm)     begin cm = 4'b0000; b = 3'b011; a = mr3; end
    else if (k == sc + 2 * sm) begin cm = 4'b0000; b = 3'b001; a = mr1; end
    else if (k == sc + 3 * sm) begin cm = 4'b0000; b = 3'b000; a = mr0; end
    else if (k == sd)          begin cm = 4'b0110; a[10] = 1'b1; end
    return pack(k >= sa, k >= sb, 1'b0, k >= se, cm, b, a);
  endfunction

  function automatic string tag_of(input logic [24:0] g, input logic [24:0] e, input int k);
    if (k == 0 && g != e)   return "R1";
    if (g[24] != e[24])     return "R2";
    if (g[23] != e[23])     return e[24] ? "R3" : "R11";
    if (g[22] != e[22])     return "R10";
    if (g[21] != e[21])     return "R8";
    if (k == sc)            return "R4";
    if (k == sd)            return "R7";
    if (e[20:17] == 4'b0000) return "R5 R6";
    return "R9";
  endfunction

  task automatic check_vec(input int k);
    logic [24:0] g, e;
    g = pack(mem_rst_n, cke, odt, ready, cmd, ba, addr);
    e = exp_vec(k);
    n_vec++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag_of(g, e, k), k, g, e);
    end
  endtask

  task automatic run_seq(input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      check_vec(k);
      @(negedge clk_i);
    end
  endtask

  task automatic kick();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic rand_cfg();
    t_rst  = CNT_W'($urandom_range(40));
    t_stab = CNT_W'($urandom_range(200));
    t_xpr  = CNT_W'($urandom_range(20));
    t_mrd  = CNT_W'($urandom_range(8));
    t_mod  = CNT_W'($urandom_range(15));
    t_zq   = CNT_W'($urandom_range(120));
    t_dllk = CNT_W'($urandom_range(120));
    mr0 = AW'($urandom); mr1 = AW'($urandom);
    mr2 = AW'($urandom); mr3 = AW'($urandom);
    set_sched();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // floors hit: every configured delay below its minimum (R2 R4 R7 R8)
    t_rst = 1; t_stab = 0; t_xpr = 0; t_mrd = 0; t_mod = 0; t_zq = 0; t_dllk = 0;
    mr0 = 14'h1520; mr1 = 14'h0044; mr2 = 14'h0018; mr3 = 14'h0000;
    set_sched();
    repeat (3) @(negedge clk_i);
    check_vec(0);  // R1 reset state
    rst_ni = 1'b1;
    run_seq(se + 6);

    // DLL lock longer than calibration (R8), wider mode spacing (R6)
    t_rst = 30; t_stab = 50; t_xpr = 9; t_mrd = 4; t_mod = 12; t_zq = 20; t_dllk = 90;
    set_sched();
    kick();
    run_seq(se + 4);

    // restart in the middle of the mode writes (R1)
    kick();
    run_seq(sc + sm + 1);
    kick();
    check_vec(0);  // R1 restart clears phase and index
    @(negedge clk_i);
    run_seq(0);
    kick();
    run_seq(se + 3);

    // restart while ready, then random configurations
    for (int i = 0; i < 10; i++) begin
      rand_cfg();
      kick();
      run_seq(se + 5);
    end

    // asynchronous reset mid sequence (R1)
    kick();
    run_seq(sb + 2);
    rst_ni = 1'b0;
    #1;
    check_vec(0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_seq(se + 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule